// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block raises a periodic interrupt request at a rate that software selects. It counts qualified bus-clock cycles, marked by a one-cycle `tick` strobe, and each time the selected interval has elapsed it sets a sticky pending flag. A separate enable bit decides whether that flag reaches the interrupt output. Software clears the flag by writing a 1 to its bit.

Three byte-wide registers sit behind a small select field. The rate register holds a two-bit rate code R, and the interval is 2^BASE_LOG2 × 2^R ticks. With the default BASE_LOG2 of 13, the intervals are 8192, 16384, 32768 and 65536 ticks. The enable register holds the interrupt enable and the flag register holds the pending flag. Writing the rate register restarts the interval from zero. Reads return the selected register combinationally.

Top module: `rtick_irq`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0x00 (rate code 0, enable 0, flag 0), `irq` is 0 and the interval restarts from zero.
- R2: The rate code is bits [1:0] of the rate register (select 0). The flag becomes set after exactly 2^BASE_LOG2 × 2^R counted ticks. After one tick fewer, it is still clear.
- R3: Cycles with `tick` low do not advance the interval.
- R4: Once set, the flag stays set until software clears it, regardless of further ticks or idle cycles.
- R5: The flag is bit 6 of the flag register (select 2). Writing that register with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged, whatever the other bits hold.
- R6: The enable is bit 6 of the enable register (select 1). `irq` is 1 exactly when both the flag and the enable are 1.
- R7: A write to the rate register restarts the interval at zero. A tick in the same cycle is discarded, and the write does not set the flag.
- R8: If the interval expires in the same cycle that software clears the flag, the flag stays set.
- R9: Unused register bits read 0, and select 3 reads 0x00. Unused bits written to the rate or enable register are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe: one counted bus cycle |
| reg_sel | input | 2 | Register select: 0 rate, 1 enable, 2 flag, 3 none |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: an expiry of the interval setting the flag, and a software write clearing it. The bench provokes this by running the counter to one tick short of its limit with the flag already set, then driving the final tick and a write of 0x40 to the flag register in the same cycle. The flag must still read 0x40 afterwards, and a later clear with no tick must take it to 0x00. A rate-register write carrying a tick is judged in the same way: the following full interval must be needed before the flag appears.

// File: rtl/rtick_pkg.sv
// Shared definitions for the periodic interrupt timer.
// Assumes byte-wide registers with the flag and enable at bit 6.
package rtick_pkg;
    typedef enum logic [1:0] {
        SEL_RATE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int FLAG_BIT = 6;
    localparam int EN_BIT   = 6;
endpackage

// File: rtl/rtick_regs.sv
// Register decode for the periodic interrupt timer: holds the rate code
// and the interrupt enable, and turns writes into restart and clear strobes.
// Assumes DATA_W covers bit 6.
module rtick_regs #(
    parameter int DATA_W = 8,
    parameter int RATE_W = 2,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [RATE_W-1:0] rate,
    output logic              irq_en,
    output logic              restart,
    output logic              clr_req
);
    import rtick_pkg::*;

    logic hit_rate, hit_mask, hit_flag;

    // Decode which register a write targets.
    always_comb begin
        hit_rate = wr_en && (reg_sel == SEL_W'(SEL_RATE));
        hit_mask = wr_en && (reg_sel == SEL_W'(SEL_MASK));
        hit_flag = wr_en && (reg_sel == SEL_W'(SEL_FLAG));
    end

    // Store the rate code and the enable; other bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate   <= '0;
            irq_en <= 1'b0;
        end else begin
            if (hit_rate) rate   <= wr_data[RATE_W-1:0];
            if (hit_mask) irq_en <= wr_data[EN_BIT];
        end
    end

    // Strobes: a rate write restarts the interval, and a 1 at the flag bit clears it.
    always_comb begin
        restart = hit_rate;
        clr_req = hit_flag && wr_data[FLAG_BIT];
    end
endmodule

// File: rtl/rtick_interval.sv
// Interval counter: counts tick cycles up to 2^(BASE_LOG2+rate)-1 and
// pulses expire on the tick that completes the interval.
// Assumes rate changes only together with restart.
module rtick_interval #(
    parameter int BASE_LOG2 = 13,
    parameter int RATE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              expire
);
    localparam int CNT_W = BASE_LOG2 + (2 ** RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected rate.
    always_comb begin
        span   = (CNT_W+1)'(1) << (BASE_LOG2 + int'(rate));
        limit  = CNT_W'(span - (CNT_W+1)'(1));
        expire = tick && !restart && (cnt == limit);
    end

    // Advance on tick, wrap at the limit, zero on restart or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (expire)       cnt <= '0;
        else if (tick)         cnt <= cnt + CNT_W'(1);
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);
    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/rtick_flag.sv
// Sticky pending flag: set by an interval expiry, cleared by software.
// When both happen in one cycle, the set wins.
module rtick_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    output logic flag
);
    // Hold, clear or set the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (expire)  flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !flag);
    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/rtick_irq.sv
// Periodic interrupt timer top: wires the register decode, the interval
// counter and the sticky flag together, and provides the read mux and irq.
// Assumes tick is a one-cycle strobe synchronous to clk.
module rtick_irq #(
    parameter int BASE_LOG2 = 13,
    parameter int RATE_W    = 2,
    parameter int DATA_W    = 8,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import rtick_pkg::*;

    logic [RATE_W-1:0] rate;
    logic              irq_en, restart, clr_req, expire, flag;

    rtick_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rate(rate), .irq_en(irq_en),
        .restart(restart), .clr_req(clr_req)
    );

    rtick_interval #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .rate(rate), .expire(expire)
    );

    rtick_flag u_flag (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
        .flag(flag)
    );

    // Gate the pending flag with the enable.
    always_comb irq = flag && irq_en;

    // Return the selected register; unused bits read zero.
    always_comb begin
        rd_data = '0;
        case (reg_sel)
            SEL_W'(SEL_RATE): rd_data[RATE_W-1:0] = rate;
            SEL_W'(SEL_MASK): rd_data[EN_BIT]     = irq_en;
            SEL_W'(SEL_FLAG): rd_data[FLAG_BIT]   = flag;
            default:          rd_data             = '0;
        endcase
    end

    // R6
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_W'(SEL_MASK) && !wr_data[EN_BIT]) |=> !irq);
endmodule

// File: tb/rtick_irq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for rtick_irq, run with a small base interval (64 ticks).
module rtick_irq_bench;
    localparam int BL = 6;
    localparam int P0 = 1 << BL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp_data;
        logic       exp_irq;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    rtick_irq #(.BASE_LOG2(BL)) u_rtick_irq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: pop expected items and compare with the outputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rd_data !== it.exp_data || irq !== it.exp_irq) begin
                errors++;
                $display("FAIL %s: rd_data=%02h irq=%b expected rd_data=%02h irq=%b",
                         it.tag, rd_data, irq, it.exp_data, it.exp_irq);
            end
        end
    end

    task automatic expect_rd(input logic [1:0] s, input logic [7:0] d,
                             input logic i, input string tag);
        item_t it;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0; reg_sel = s;
        it.exp_data = d; it.exp_irq = i; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            tick = 1'b1; wr_en = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            tick = 1'b0; wr_en = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic tk);
        @(posedge clk); #1;
        wr_en = 1'b1; reg_sel = s; wr_data = d; tick = tk;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        do_reset();
        expect_rd(2'd0, 8'h00, 1'b0, "R1 rate after reset");
        expect_rd(2'd1, 8'h00, 1'b0, "R1 enable after reset");
        expect_rd(2'd2, 8'h00, 1'b0, "R1 flag after reset");

        run_ticks(P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R2 rate0 one tick short");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b0, "R2 rate0 expiry, R6 irq off when disabled");
        run_ticks(40);
        idle(30);
        expect_rd(2'd2, 8'h40, 1'b0, "R4 flag sticky");

        wr(2'd2, 8'h00, 1'b0);
        expect_rd(2'd2, 8'h40, 1'b0, "R5 write zero keeps flag");
        wr(2'd2, 8'hBF, 1'b0);
        expect_rd(2'd2, 8'h40, 1'b0, "R5 write other bits keeps flag");
        wr(2'd2, 8'h40, 1'b0);
        expect_rd(2'd2, 8'h00, 1'b0, "R5 write one clears flag");

        // The counter stands at 40 of 64.
        run_ticks(20);
        idle(50);
        run_ticks(3);
        expect_rd(2'd2, 8'h00, 1'b0, "R3 idle cycles not counted");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b0, "R3 expiry after counted ticks only");
        wr(2'd2, 8'h40, 1'b0);

        wr(2'd1, 8'hFF, 1'b0);
        expect_rd(2'd1, 8'h40, 1'b0, "R9 enable unused bits, R6 irq off with flag clear");
        run_ticks(P0);
        expect_rd(2'd2, 8'h40, 1'b1, "R6 irq with flag and enable");
        wr(2'd1, 8'h00, 1'b0);
        expect_rd(2'd2, 8'h40, 1'b0, "R6 irq off when enable cleared");
        wr(2'd1, 8'h40, 1'b0);
        wr(2'd2, 8'h40, 1'b0);
        expect_rd(2'd2, 8'h00, 1'b0, "R6 irq off after clear");

        wr(2'd0, 8'hFD, 1'b0);
        expect_rd(2'd0, 8'h01, 1'b0, "R9 rate unused bits");
        run_ticks(2*P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R2 rate1 one tick short");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b1, "R2 rate1 expiry");
        wr(2'd2, 8'h40, 1'b0);

        run_ticks(100);
        wr(2'd0, 8'h01, 1'b1);
        expect_rd(2'd2, 8'h00, 1'b0, "R7 rate write sets no flag");
        run_ticks(2*P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R7 interval restarted, tick discarded");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b1, "R7 expiry after full interval");

        run_ticks(2*P0 - 1);
        wr(2'd2, 8'h40, 1'b1);
        expect_rd(2'd2, 8'h40, 1'b1, "R8 expiry beats clear");
        wr(2'd2, 8'h40, 1'b0);
        expect_rd(2'd2, 8'h00, 1'b0, "R8 later clear works");

        wr(2'd0, 8'h03, 1'b0);
        run_ticks(8*P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R2 rate3 one tick short");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b1, "R2 rate3 expiry");
        wr(2'd2, 8'h40, 1'b0);
        wr(2'd0, 8'h02, 1'b0);
        run_ticks(4*P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R2 rate2 one tick short");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b1, "R2 rate2 expiry");
        expect_rd(2'd3, 8'h00, 1'b1, "R9 select 3 reads zero");

        run_ticks(30);
        do_reset();
        expect_rd(2'd2, 8'h00, 1'b0, "R1 flag cleared by reset");
        expect_rd(2'd0, 8'h00, 1'b0, "R1 rate cleared by reset");
        run_ticks(P0 - 1);
        expect_rd(2'd2, 8'h00, 1'b0, "R1 interval restarted by reset");
        run_ticks(1);
        expect_rd(2'd2, 8'h40, 1'b0, "R1 first expiry after reset");

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule